// File: doc/BRIEF.md
# Synchronous Serial Port (SPI Master/Slave)

This block is an 8-bit SPI port that sits on a small on-chip register bus. Software writes a byte into the data register to send it and reads the data register to collect the byte that came back. In master role, a write starts a transfer right away, and the port makes the serial clock from the system clock through a selectable divider. In slave role, the same write only preloads the shift register. An external master then clocks the byte out, and the block resynchronises that external clock before using it.

The control register holds the enable, the idle clock level, a 4-bit mode code and two sticky error flags. The collision flag records a data write that was refused because a transfer was in progress. The overflow flag records a byte that was received in slave role while the previous byte was still unread; that new byte is thrown away. A status register shows whether the receive buffer holds an unread byte and whether a transfer is running.

Top module: `spi_port`

## Requirements
- R1: Register addresses are 0 = data, 1 = control and 2 = status. Control bits are: bit0 enable, bit1 idle clock level, bits5:2 mode, bit6 collision flag, bit7 overflow flag. Status bits are: bit0 buffer full, bit1 transfer busy. After reset, all registers read 0 and both output enables are low. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R2: Mode codes 0000, 0001 and 0010 select master role. In master role, a data write while idle starts an 8-bit transfer, and the clock spends 2, 8 or 32 system cycles per bit at the non-idle level (SCK period 4, 16 or 64 cycles). The received byte is then readable from the data register.
- R3: In master role the overflow flag never sets. A second received byte replaces an unread first byte.
- R4: Mode codes 0100 and 0101 select slave role. A byte written beforehand is shifted out on `sdo_o` while the byte arriving on `sdi_i` is captured into the receive buffer.
- R5: Bits move most significant first. The output bit changes on the SCK edge that leaves the idle level, and the input bit is sampled on the edge that returns to it. This holds in both roles.
- R6: Status bit0 sets when a received byte enters the buffer and clears when the data register is read. Status bit1 is high while a transfer runs.
- R7: In slave role, a byte that completes while the buffer is full sets the overflow flag. The buffer keeps the older byte and the new one is discarded.
- R8: A data write during a transfer sets the collision flag and is ignored: the byte being shifted out is not changed.
- R9: The collision and overflow flags stay set until a control write with a 0 in their bit position. Writing a 1 to a flag never sets it.
- R10: With enable low, `sck_oe` and `sdo_oe` are low and a data write starts no transfer.
- R11: When idle in master role, `sck_o` equals the idle level bit (1 = idle high).
- R12: In mode 0100, `ss_n_i` high holds `sdo_oe` low. Raising `ss_n_i` in the middle of a byte restarts the bit count, so the next byte is received whole.
- R13: In mode 0101, `ss_n_i` is ignored: the port drives `sdo_oe` and transfers bytes while `ss_n_i` is high.
- R14: Any other mode code leaves the port inactive: no outputs are driven and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sck_i | input | 1 | Serial clock from the external master (slave role) |
| sck_o | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Output enable for sck_o |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo_o |
| sdi_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
Register reads are due on the cycle after the read strobe, so the bench samples `bus_rdata` at the falling edge one full cycle after it raises `bus_rd`. A master transfer ends 16 half-bit periods after the write: 8·N cycles for SCK period N, plus one cycle to update the buffer. The bench waits 8·N + 8 cycles before it reads status or data. In slave role every bench clock edge passes through a two-stage synchroniser and an edge detector, so the block reacts about three cycles late. The bench therefore holds each half bit for 8 cycles, samples `sdo_o` just before its returning edge, and waits at least 6 cycles after the last edge before it reads results.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  typedef struct packed {
    logic       ovf;
    logic       col;
    logic [3:0] mode;
    logic       cpol;
    logic       en;
  } ctrl_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam logic [3:0] MODE_SLV_SS  = 4'd4;
  localparam logic [3:0] MODE_SLV_NSS = 4'd5;

  function automatic role_e role_of(input logic en, input logic [3:0] mode);
    if (!en) return ROLE_OFF;
    if (mode <= 4'd2) return ROLE_MASTER;
    if (mode == MODE_SLV_SS || mode == MODE_SLV_NSS) return ROLE_SLAVE;
    return ROLE_OFF;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int BASE_HALF = 2,
  parameter int STEP_LOG2 = 2,
  parameter int NSEL      = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int MAX_HALF = BASE_HALF << (STEP_LOG2 * (NSEL - 1));
  localparam int CW       = $clog2(MAX_HALF) + 1;

  logic [CW-1:0] half_tbl [NSEL];
  logic [CW-1:0] half_sel;
  logic [CW-1:0] cnt;

  for (genvar g = 0; g < NSEL; g++) begin : g_half
    assign half_tbl[g] = CW'(BASE_HALF << (STEP_LOG2 * g));
  end

  always_comb begin
    half_sel = half_tbl[0];
    for (int i = 0; i < NSEL; i++)
      if (sel == 2'(i)) half_sel = half_tbl[i];
  end

  assign tick = run && (cnt == half_sel - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  role_e         role,
  input  logic          cpol,
  input  logic          ss_ignore,
  input  logic          m_tick,
  input  logic          m_sdi,
  input  logic          s_sck,
  input  logic          s_ss_n,
  input  logic          s_sdi,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          busy,
  output logic          m_busy,
  output logic          phase,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int BW = $clog2(DW);

  logic [DW-1:0] sr;
  logic [DW-1:0] sr_next;
  logic [BW-1:0] bits;
  logic          sck_prev;
  logic          ss_act, s_chg, s_lead, s_trail, m_lead, m_trail, in_bit;

  assign ss_act  = ss_ignore | ~s_ss_n;
  assign s_chg   = (role == ROLE_SLAVE) && ss_act && (s_sck != sck_prev);
  assign s_lead  = s_chg && (s_sck != cpol);
  assign s_trail = s_chg && (s_sck == cpol) && phase;
  assign m_lead  = (role == ROLE_MASTER) && m_busy && m_tick && !phase;
  assign m_trail = (role == ROLE_MASTER) && m_busy && m_tick && phase;
  assign in_bit  = (role == ROLE_MASTER) ? m_sdi : s_sdi;
  assign sr_next = {sr[DW-2:0], in_bit};
  assign busy    = m_busy | ((role == ROLE_SLAVE) && ((bits != '0) || phase));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      bits     <= '0;
      phase    <= 1'b0;
      m_busy   <= 1'b0;
      done     <= 1'b0;
      rx_byte  <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= s_sck;
      done     <= 1'b0;
      sdo_oe   <= (role == ROLE_MASTER) || ((role == ROLE_SLAVE) && ss_act);
      if (load) begin
        sr     <= load_data;
        bits   <= '0;
        phase  <= 1'b0;
        m_busy <= (role == ROLE_MASTER);
      end else if (role == ROLE_OFF || (role == ROLE_SLAVE && !ss_act)) begin
        bits   <= '0;
        phase  <= 1'b0;
        m_busy <= 1'b0;
      end else if (s_lead || m_lead) begin
        phase <= 1'b1;
        sdo   <= sr[DW-1];
      end else if (s_trail || m_trail) begin
        phase <= 1'b0;
        sr    <= sr_next;
        if (bits == BW'(DW - 1)) begin
          bits    <= '0;
          m_busy  <= 1'b0;
          done    <= 1'b1;
          rx_byte <= sr_next;
        end else begin
          bits <= bits + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  role_e         role,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output ctrl_t         ctrl,
  output logic          load,
  output logic [DW-1:0] load_data,
  output logic          full,
  output logic [DW-1:0] rx_buf,
  output logic [DW-1:0] rdata
);
  logic wr_data, wr_ctrl, rd_data, col_set, ovf_set, take;
  ctrl_t wctl;
  logic [DW-1:0] stat;

  assign wctl      = ctrl_t'(bus_wdata[7:0]);
  assign wr_data   = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_data   = bus_rd && (bus_addr == ADDR_DATA);
  assign load      = wr_data && !busy;
  assign load_data = bus_wdata;
  assign col_set   = wr_data && busy;
  assign ovf_set   = done && full && !rd_data && (role == ROLE_SLAVE);
  assign take      = done && !ovf_set;

  always_comb begin
    stat    = '0;
    stat[0] = full;
    stat[1] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      full   <= 1'b0;
      rx_buf <= '0;
      rdata  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.en   <= wctl.en;
        ctrl.cpol <= wctl.cpol;
        ctrl.mode <= wctl.mode;
        ctrl.col  <= (ctrl.col & wctl.col) | col_set;
        ctrl.ovf  <= (ctrl.ovf & wctl.ovf) | ovf_set;
      end else begin
        ctrl.col  <= ctrl.col | col_set;
        ctrl.ovf  <= ctrl.ovf | ovf_set;
      end
      if (take) begin
        rx_buf <= rx_byte;
        full   <= 1'b1;
      end else if (rd_data) begin
        full   <= 1'b0;
      end
      if (bus_rd) begin
        case (bus_addr)
          ADDR_DATA: rdata <= rx_buf;
          ADDR_CTRL: rdata <= DW'(ctrl);
          ADDR_STAT: rdata <= stat;
          default:   rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BASE_HALF = 2,
  parameter int STEP_LOG2 = 2,
  parameter int NSEL      = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  output logic          sdo_o,
  output logic          sdo_oe,
  input  logic          sdi_i,
  input  logic          ss_n_i
);
  ctrl_t         ctrl;
  role_e         role;
  logic          ctrl_en, ctrl_cpol, ovf_flag, col_flag, ss_ignore;
  logic          load, busy, m_busy, phase, done, m_tick, full;
  logic [DW-1:0] load_data, rx_byte, rx_buf;
  logic [2:0]    pins_sync;

  assign ctrl_en   = ctrl.en;
  assign ctrl_cpol = ctrl.cpol;
  assign ovf_flag  = ctrl.ovf;
  assign col_flag  = ctrl.col;
  assign role      = role_of(ctrl.en, ctrl.mode);
  assign ss_ignore = (ctrl.mode == MODE_SLV_NSS);

  spi_sync #(.W(3), .STAGES(SYNC_STG)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_i, ss_n_i, sdi_i}),
    .q   (pins_sync)
  );

  spi_clkgen #(.BASE_HALF(BASE_HALF), .STEP_LOG2(STEP_LOG2), .NSEL(NSEL)) i_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (m_busy),
    .sel  (ctrl.mode[1:0]),
    .tick (m_tick)
  );

  spi_shifter #(.DW(DW)) i_shifter (
    .clk       (clk),
    .rst       (rst),
    .role      (role),
    .cpol      (ctrl.cpol),
    .ss_ignore (ss_ignore),
    .m_tick    (m_tick),
    .m_sdi     (sdi_i),
    .s_sck     (pins_sync[2]),
    .s_ss_n    (pins_sync[1]),
    .s_sdi     (pins_sync[0]),
    .load      (load),
    .load_data (load_data),
    .sdo       (sdo_o),
    .sdo_oe    (sdo_oe),
    .busy      (busy),
    .m_busy    (m_busy),
    .phase     (phase),
    .done      (done),
    .rx_byte   (rx_byte)
  );

  spi_regs #(.DW(DW)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .role      (role),
    .busy      (busy),
    .done      (done),
    .rx_byte   (rx_byte),
    .ctrl      (ctrl),
    .load      (load),
    .load_data (load_data),
    .full      (full),
    .rx_buf    (rx_buf),
    .rdata     (bus_rdata)
  );

  assign sck_oe = (role == ROLE_MASTER);
  assign sck_o  = ctrl.cpol ^ (phase & m_busy);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    role,
  input logic          en,
  input logic          cpol,
  input logic          busy,
  input logic          load,
  input logic          sck_o,
  input logic          sck_oe,
  input logic          sdo_oe,
  input logic          ovf,
  input logic          col,
  input logic [DW-1:0] rx_buf,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata
);
  p_master_start_r2: assert property (@(posedge clk) disable iff (rst)
    (load && role == 2'd1) |=> busy);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> ($past(role) == 2'd2));

  p_keep_buffer_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $stable(rx_buf));

  p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(bus_wr && bus_addr == 2'd1 && !bus_wdata[7])) |=> ovf);

  p_sticky_col_r9: assert property (@(posedge clk) disable iff (rst)
    (col && !(bus_wr && bus_addr == 2'd1 && !bus_wdata[6])) |=> col);

  p_released_r10: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en)) |-> (!sck_oe && !sdo_oe));

  p_idle_level_r11: assert property (@(posedge clk) disable iff (rst)
    (sck_oe && !busy) |-> (sck_o == cpol));
endmodule

bind spi_port spi_port_chk #(.DW(DW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .role      (role),
  .en        (ctrl_en),
  .cpol      (ctrl_cpol),
  .busy      (busy),
  .load      (load),
  .sck_o     (sck_o),
  .sck_oe    (sck_oe),
  .sdo_oe    (sdo_oe),
  .ovf       (ovf_flag),
  .col       (col_flag),
  .rx_buf    (rx_buf),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/test_spi_port.sv
module test_spi_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic sck_o, sck_oe, sdo_o, sdo_oe, sdi_i;
  logic s_sck = 1'b0, s_ss = 1'b1, s_sdi = 1'b0, m_sdi = 1'b0;
  logic mon_on = 1'b0, cpol_b = 1'b0, sck_prev_b = 1'b0;
  logic [7:0] miso_pat = 8'd0, mosi_cap = 8'd0;
  int kb = 0, act_cnt = 0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  assign sdi_i = mon_on ? m_sdi : s_sdi;

  spi_port i_spi_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_i(s_sck), .sck_o(sck_o),
    .sck_oe(sck_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i), .ss_n_i(s_ss)
  );

  // Model of the far-end slave used while the port is master.
  always @(negedge clk) begin
    if (mon_on) begin
      if (sck_o != cpol_b) act_cnt++;
      if (sck_o != sck_prev_b) begin
        if (sck_o != cpol_b) begin
          if (kb < 8) m_sdi = miso_pat[7-kb];
        end else begin
          mosi_cap = {mosi_cap[6:0], sdo_o};
          kb++;
        end
      end
    end
    sck_prev_b = sck_o;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] ctl(input logic [3:0] mode, input logic cpol, input logic en);
    return {2'b00, mode, cpol, en};
  endfunction

  task automatic mon_start(input logic cpol, input logic [7:0] rx);
    cpol_b = cpol; miso_pat = rx; kb = 0; act_cnt = 0; mosi_cap = 8'd0;
    sck_prev_b = cpol; mon_on = 1'b1;
  endtask

  task automatic master_xfer(input int mode, input logic cpol, input logic [7:0] tx,
                             input logic [7:0] rx, input bit rd);
    logic [7:0] d;
    int n;
    n = 4 << (2 * mode);
    mon_on = 1'b0;
    bus_write(2'd1, ctl(4'(mode), cpol, 1'b1));
    mon_start(cpol, rx);
    bus_write(2'd0, tx);
    wait_cyc(8 * n + 8);
    chk("R2 clock cycles at active level", act_cnt, 4 * n);
    chk("R5 msb-first bits on sdo", mosi_cap, tx);
    chk("R11 idle sck level", sck_o, cpol);
    bus_read(2'd2, d);
    chk("R6 status full, not busy", d, 8'h01);
    if (rd) begin
      bus_read(2'd0, d);
      chk("R2 received byte", d, rx);
      bus_read(2'd2, d);
      chk("R6 full clears on read", d, 8'h00);
    end
  endtask

  task automatic slave_bits(input logic [7:0] mo, input int nb, input bit use_ss,
                            output logic [7:0] got);
    got = 8'd0;
    if (use_ss) s_ss = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < nb; i++) begin
      s_sck = 1'b1; s_sdi = mo[7-i];
      wait_cyc(8);
      got = {got[6:0], sdo_o};
      s_sck = 1'b0;
      wait_cyc(8);
    end
    s_ss = 1'b1;
    wait_cyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, got;
    void'($urandom(32'h5EED));
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);

    bus_read(2'd1, d); chk("R1 control reset", d, 8'h00);
    bus_read(2'd2, d); chk("R1 status reset", d, 8'h00);
    bus_read(2'd0, d); chk("R1 data reset", d, 8'h00);
    chk("R1 enables low after reset", {sck_oe, sdo_oe}, 2'b00);

    // R10: disabled port
    bus_write(2'd1, ctl(4'd0, 1'b0, 1'b0));
    bus_write(2'd0, 8'h55);
    wait_cyc(40);
    chk("R10 outputs released", {sck_oe, sdo_oe}, 2'b00);
    bus_read(2'd2, d); chk("R10 no transfer", d, 8'h00);

    // R14: unused mode code
    bus_write(2'd1, ctl(4'd3, 1'b0, 1'b1));
    bus_write(2'd0, 8'h66);
    wait_cyc(40);
    chk("R14 outputs released", {sck_oe, sdo_oe}, 2'b00);
    bus_read(2'd2, d); chk("R14 no transfer", d, 8'h00);

    // Master directed and random
    master_xfer(0, 1'b0, 8'hA5, 8'h3C, 1'b1);
    master_xfer(2, 1'b1, 8'h81, 8'h7E, 1'b1);
    master_xfer(1, 1'b0, 8'h01, 8'h80, 1'b1);
    for (int it = 0; it < 6; it++) begin
      master_xfer(int'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                  8'($urandom), 8'($urandom), 1'b1);
    end

    // R3: no overflow in master role
    master_xfer(0, 1'b0, 8'h12, 8'h34, 1'b0);
    master_xfer(0, 1'b0, 8'h56, 8'hC7, 1'b0);
    bus_read(2'd1, d); chk("R3 overflow stays clear", d[7], 1'b0);
    bus_read(2'd0, d); chk("R3 newer byte replaces", d, 8'hC7);

    // R8: collision in master role
    mon_on = 1'b0;
    bus_write(2'd1, ctl(4'd0, 1'b0, 1'b1));
    mon_start(1'b0, 8'h00);
    bus_write(2'd0, 8'hC3);
    wait_cyc(6);
    bus_write(2'd0, 8'h11);
    wait_cyc(40);
    chk("R8 write ignored, byte intact", mosi_cap, 8'hC3);
    bus_read(2'd1, d); chk("R8 collision flag set", d[6], 1'b1);
    bus_read(2'd0, d);
    // R9: sticky flags
    bus_write(2'd1, 8'hC1);
    bus_read(2'd1, d); chk("R9 writing 1 keeps flag", d[6], 1'b1);
    bus_write(2'd1, 8'h01);
    bus_read(2'd1, d); chk("R9 writing 0 clears flag", d[6], 1'b0);
    bus_write(2'd1, 8'h41);
    bus_read(2'd1, d); chk("R9 writing 1 does not set", d[6], 1'b0);
    mon_on = 1'b0;

    // Slave role with select
    bus_write(2'd1, ctl(4'd4, 1'b0, 1'b1));
    wait_cyc(8);
    chk("R12 sdo released while deselected", sdo_oe, 1'b0);
    bus_write(2'd0, 8'hA5);
    slave_bits(8'h3C, 8, 1'b1, got);
    chk("R4 slave shifts preload out", got, 8'hA5);
    bus_read(2'd2, d); chk("R6 full after slave byte", d[0], 1'b1);
    bus_read(2'd0, d); chk("R4 slave received byte", d, 8'h3C);

    // R7: overflow
    slave_bits(8'h77, 8, 1'b1, got);
    slave_bits(8'h99, 8, 1'b1, got);
    bus_read(2'd1, d); chk("R7 overflow flag set", d[7], 1'b1);
    bus_read(2'd0, d); chk("R7 older byte kept", d, 8'h77);
    bus_write(2'd1, 8'h91);
    bus_read(2'd1, d); chk("R9 overflow sticky", d[7], 1'b1);
    bus_write(2'd1, 8'h11);
    bus_read(2'd1, d); chk("R9 overflow cleared", d[7], 1'b0);

    // R12: deselect mid-byte
    slave_bits(8'hF0, 3, 1'b1, got);
    slave_bits(8'h6B, 8, 1'b1, got);
    bus_read(2'd0, d); chk("R12 count restarts after deselect", d, 8'h6B);

    // R8: collision in slave role
    bus_write(2'd0, 8'h5A);
    fork
      slave_bits(8'h81, 8, 1'b1, got);
      begin
        wait_cyc(40);
        bus_write(2'd0, 8'hFF);
      end
    join
    chk("R8 slave byte intact", got, 8'h5A);
    bus_read(2'd1, d); chk("R8 slave collision flag", d[6], 1'b1);
    bus_read(2'd0, d); chk("R4 slave byte after collision", d, 8'h81);

    // R13: select ignored
    bus_write(2'd1, ctl(4'd5, 1'b0, 1'b1));
    wait_cyc(8);
    chk("R13 sdo driven while ss high", sdo_oe, 1'b1);
    bus_write(2'd0, 8'h24);
    slave_bits(8'hB2, 8, 1'b0, got);
    chk("R13 byte out with ss high", got, 8'h24);
    bus_read(2'd0, d); chk("R13 byte in with ss high", d, 8'hB2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule